// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Bank (one core)

This block is the register bank that one processor core owns for inter-processor interrupts. It sits behind a 32-bit register interface and decodes an 8-bit local offset. It contains a read-only pending word, an enable word, two write-only ports that set or clear pending bits, and eight 32-bit mailbox words that software uses to pass messages between cores. It drives a single interrupt line toward its core.

A sender on another core posts an interrupt by writing the set port. It can do this through the bus or through a dedicated remote-write input. The local core acknowledges by writing the clear port. The interrupt line has deliberately asymmetric rules. It can only go high on a set, when the pending word has bits that are also enabled. It can only go low on a clear that empties the pending word while the enable word is nonzero. Writing the enable word never moves the line by itself.

A 64-bit access is handled as two 32-bit operations. The low half goes to the addressed word and the high half to the word 4 bytes above it. For a write, the low half is applied first. Read data and error pulses are registered and appear one cycle after the request.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset the pending word, enable word, all mailbox words and `irq` are zero, and `rd_valid`, `err_ro` and `err_unmapped` are low.
- R2: Only `bus_addr[7:0]` selects a register. Higher address bits are ignored, so an access to 0xAB04 reaches the same word as 0x0004.
- R3: The pending word (offset 0x00) is read-only. A bus write to it leaves it unchanged and pulses `err_ro` high in the following cycle.
- R4: The enable word (offset 0x04) reads back exactly the last value written to it.
- R5: A write to the set port (offset 0x08) ORs the data into the pending word. Afterwards `irq` is driven high if the pending word is nonzero and (pending AND enable) is nonzero; otherwise `irq` keeps its value.
- R6: A write to the clear port (offset 0x0C) clears the pending bits that are 1 in the data. Afterwards `irq` is driven low only if the pending word is zero and the enable word is nonzero; otherwise `irq` keeps its value.
- R7: Reads of offsets 0x08 and 0x0C return zero and are not flagged as unmapped.
- R8: Offsets 0x20 to 0x3F hold eight read/write mailbox words. The word index is (offset − 0x20) / 4.
- R9: When `bus_wide` is 1, the low 32 data bits act on the addressed offset and the high 32 bits act on offset+4. Writes are applied low half first, then high half, in the same cycle. A wide read returns {word at offset+4, word at offset}.
- R10: A read of any offset outside 0x00–0x0F and 0x20–0x3F returns zero in that half and pulses `err_unmapped` together with `rd_valid`.
- R11: A remote write (`rmt_valid`) acts on the set port when `rmt_clr` is 0 and on the clear port when `rmt_clr` is 1. If it arrives in the same cycle as a bus write, the bus write is applied first.
- R12: In a cycle with no set or clear operation, `irq` does not change. In particular, writing the enable word never raises or lowers it.
- R13: A bus read produces `rd_valid` with the read data in the following cycle. The data is the register state from before any write in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_wide | input | 1 | 1 for a 64-bit access split into two words |
| bus_addr | input | ADDR_W | Access address; only bits 7:0 are decoded |
| bus_wdata | input | 64 | Write data; high word used only when wide |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 64 | Read data; high word zero for 32-bit reads |
| err_ro | output | 1 | Pulse: write to the read-only pending word |
| err_unmapped | output | 1 | Pulse: read of an unmapped offset |
| rmt_valid | input | 1 | Remote write request |
| rmt_clr | input | 1 | Remote target: 0 set port, 1 clear port |
| rmt_data | input | 32 | Remote write data |
| irq | output | 1 | Interrupt line toward the core |

## Verification
The assertions take for granted that bus addresses are word aligned, that each request is held for exactly one cycle, and that `bus_write` qualifies a request as either read or write but never both. The stimulus uses only aligned offsets and one request per cycle. Remote writes overlap bus writes only in cycles set up to test ordering. Under those inputs the properties tie `irq` and pending-word movement to set or clear activity. They also tie every fall of `irq` to an empty pending word with a nonzero enable word.

// File: rtl/ipi_core_regs.sv
module ipi_core_regs #(
  parameter int ADDR_W = 16,
  parameter int MB_N   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              err_ro,
  output logic              err_unmapped,
  input  logic              rmt_valid,
  input  logic              rmt_clr,
  input  logic [31:0]       rmt_data,
  output logic              irq
);
  localparam int MBW = (MB_N > 1) ? $clog2(MB_N) : 1;
  localparam logic [5:0] W_ST  = 6'h00;
  localparam logic [5:0] W_EN  = 6'h01;
  localparam logic [5:0] W_SET = 6'h02;
  localparam logic [5:0] W_CLR = 6'h03;
  localparam int         W_MB  = 8;

  logic [31:0] status_q, en_q, st_n, en_n;
  logic [31:0] mbox_q [MB_N];
  logic [31:0] mb_n   [MB_N];
  logic        irq_n;

  logic [7:0] off_lo, off_hi;
  logic       wr_lo, wr_hi, rd_req;
  assign off_lo = bus_addr[7:0];
  assign off_hi = off_lo + 8'd4;
  assign wr_lo  = bus_valid && bus_write;
  assign wr_hi  = wr_lo && bus_wide;
  assign rd_req = bus_valid && !bus_write;

  function automatic logic is_mb(input logic [7:0] off);
    return int'(off[7:2]) >= W_MB && int'(off[7:2]) < W_MB + MB_N;
  endfunction

  function automatic logic [MBW-1:0] mb_idx(input logic [7:0] off);
    return MBW'(off[7:2] - 6'(W_MB));
  endfunction

  logic        op_v   [3];
  logic [7:0]  op_off [3];
  logic [31:0] op_d   [3];
  assign op_v[0]   = wr_lo;
  assign op_off[0] = off_lo;
  assign op_d[0]   = bus_wdata[31:0];
  assign op_v[1]   = wr_hi;
  assign op_off[1] = off_hi;
  assign op_d[1]   = bus_wdata[63:32];
  assign op_v[2]   = rmt_valid;
  assign op_off[2] = rmt_clr ? 8'h0C : 8'h08;
  assign op_d[2]   = rmt_data;

  always_comb begin
    st_n  = status_q;
    en_n  = en_q;
    irq_n = irq;
    mb_n  = mbox_q;
    for (int k = 0; k < 3; k++) begin
      if (op_v[k]) begin
        if (is_mb(op_off[k])) begin
          mb_n[mb_idx(op_off[k])] = op_d[k];
        end else begin
          case (op_off[k][7:2])
            W_EN:  en_n = op_d[k];
            W_SET: begin
              st_n = st_n | op_d[k];
              if (st_n != '0 && (st_n & en_n) != '0) irq_n = 1'b1;
            end
            W_CLR: begin
              st_n = st_n & ~op_d[k];
              if (st_n == '0 && en_n != '0) irq_n = 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [32:0] rd_word(input logic [7:0] off);
    if (is_mb(off)) return {1'b1, mbox_q[mb_idx(off)]};
    case (off[7:2])
      W_ST:         return {1'b1, status_q};
      W_EN:         return {1'b1, en_q};
      W_SET, W_CLR: return {1'b1, 32'h0};
      default:      return {1'b0, 32'h0};
    endcase
  endfunction

  logic [32:0] rw_lo, rw_hi;
  assign rw_lo = rd_word(off_lo);
  assign rw_hi = bus_wide ? rd_word(off_hi) : {1'b1, 32'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q     <= '0;
      en_q         <= '0;
      irq          <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      err_ro       <= 1'b0;
      err_unmapped <= 1'b0;
      for (int i = 0; i < MB_N; i++) mbox_q[i] <= '0;
    end else begin
      status_q     <= st_n;
      en_q         <= en_n;
      irq          <= irq_n;
      mbox_q       <= mb_n;
      rd_valid     <= rd_req;
      rd_data      <= rd_req ? {rw_hi[31:0], rw_lo[31:0]} : 64'h0;
      err_unmapped <= rd_req && !(rw_lo[32] && rw_hi[32]);
      err_ro       <= (wr_lo && off_lo[7:2] == W_ST) || (wr_hi && off_hi[7:2] == W_ST);
    end
  end

  logic setclr_hit;
  assign setclr_hit = rmt_valid
    || (wr_lo && (off_lo[7:2] == W_SET || off_lo[7:2] == W_CLR))
    || (wr_hi && (off_hi[7:2] == W_SET || off_hi[7:2] == W_CLR));

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !setclr_hit |=> $stable(irq));
  p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !setclr_hit |=> $stable(status_q));
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status_q == '0 && en_q != '0));
  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> status_q != '0);
  p_rd_lat_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_um_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |-> rd_valid);
endmodule

// File: tb/ipi_core_regs_tb.sv
module ipi_core_regs_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0, bus_wide = 0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        rd_valid, err_ro, err_unmapped, irq;
  logic [63:0] rd_data;
  logic        rmt_valid = 0, rmt_clr = 0;
  logic [31:0] rmt_data = '0;

  int tests = 0, fails = 0;
  logic [63:0] q_data [$];
  logic        q_um   [$];
  string       q_tag  [$];

  always #2 clk = ~clk;

  ipi_core_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_ro(err_ro),
    .err_unmapped(err_unmapped), .rmt_valid(rmt_valid), .rmt_clr(rmt_clr),
    .rmt_data(rmt_data), .irq(irq));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_data.size() == 0) chk("R13 unexpected rd_valid", 1, 0);
      else begin
        string t = q_tag.pop_front();
        chk(t, rd_data, q_data.pop_front());
        chk({t, " err_unmapped"}, err_unmapped, q_um.pop_front());
      end
    end
  end

  task automatic wr(logic [15:0] a, logic [63:0] d, logic wide = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wide = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [63:0] exp, logic um, string tag, logic wide = 0);
    @(negedge clk);
    q_data.push_back(exp); q_um.push_back(um); q_tag.push_back(tag);
    bus_valid = 1; bus_write = 0; bus_wide = wide; bus_addr = a;
    @(negedge clk);
    bus_valid = 0; bus_wide = 0;
  endtask

  task automatic rmt(logic clr, logic [31:0] d, logic with_bus, logic [15:0] a, logic [31:0] bd);
    @(negedge clk);
    rmt_valid = 1; rmt_clr = clr; rmt_data = d;
    if (with_bus) begin bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = {32'h0, bd}; end
    @(negedge clk);
    rmt_valid = 0; bus_valid = 0; bus_write = 0;
  endtask

  initial begin
    #200000;
    chk("watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", irq, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 err_ro", err_ro, 0);
    rd(16'h00, 0, 0, "R1 status");
    rd(16'h04, 0, 0, "R1 enable");
    rd(16'h3C, 0, 0, "R1 mailbox");

    wr(16'h04, 32'hF0);
    rd(16'h04, 32'hF0, 0, "R4 enable readback");

    wr(16'h08, 32'h01);
    chk("R5 masked set no irq", irq, 0);
    rd(16'h00, 32'h01, 0, "R5 status after set");
    wr(16'h08, 32'h10);
    chk("R5 enabled set irq", irq, 1);
    rd(16'h08, 0, 0, "R7 set reads zero");
    rd(16'h0C, 0, 0, "R7 clear reads zero");

    wr(16'h0C, 32'h10);
    chk("R6 partial clear holds irq", irq, 1);
    rd(16'h00, 32'h01, 0, "R6 status after clear");
    wr(16'h0C, 32'h01);
    chk("R6 full clear drops irq", irq, 0);

    wr(16'h08, 32'h20);
    chk("R5 irq up", irq, 1);
    wr(16'h04, 32'h0);
    chk("R12 enable off keeps irq", irq, 1);
    wr(16'h0C, 32'h20);
    chk("R6 clear with enable zero keeps irq", irq, 1);
    wr(16'h04, 32'hF0);
    chk("R12 enable on keeps irq", irq, 1);
    wr(16'h0C, 32'h0);
    chk("R6 empty clear with enable drops irq", irq, 0);

    wr(16'h00, 32'hFF);
    chk("R3 err_ro pulse", err_ro, 1);
    rd(16'h00, 0, 0, "R3 status unchanged");
    chk("R3 err_ro clears", err_ro, 0);

    for (int i = 0; i < 8; i++) wr(16'(16'h20 + 4*i), 32'hA500_0000 | (i * 32'h11));
    for (int i = 0; i < 8; i++) rd(16'(16'h20 + 4*i), 32'hA500_0000 | (i * 32'h11), 0, "R8 mailbox");
    rd(16'h38, {32'hA500_0077, 32'hA500_0066}, 0, "R9 wide read", 1);

    wr(16'hAB04, 32'h0F);
    rd(16'h0004, 32'h0F, 0, "R2 alias enable");
    rd(16'h5524, 32'hA500_0011, 0, "R2 alias mailbox");

    wr(16'h04, {32'h2, 32'h2}, 1);
    chk("R9 enable then set order irq", irq, 1);
    rd(16'h00, 32'h2, 0, "R9 status high half");
    rd(16'h04, 32'h2, 0, "R9 enable low half");
    wr(16'h0C, 32'h2);
    chk("R6 drop irq", irq, 0);
    wr(16'h28, {32'hBBBB_0003, 32'hAAAA_0002}, 1);
    rd(16'h28, 32'hAAAA_0002, 0, "R9 wide write low");
    rd(16'h2C, 32'hBBBB_0003, 0, "R9 wide write high");

    rd(16'h40, 0, 1, "R10 unmapped 0x40");
    rd(16'h10, 0, 1, "R10 unmapped 0x10");
    rd(16'hFC, 0, 1, "R10 unmapped 0xFC");
    rd(16'h1C, {32'hA500_0000, 32'h0}, 1, "R10 wide half unmapped", 1);

    rmt(0, 32'h4, 0, 0, 0);
    chk("R11 remote set masked", irq, 0);
    rd(16'h00, 32'h4, 0, "R11 remote set");
    rmt(0, 32'h8, 1, 16'h0C, 32'h8);
    rd(16'h00, 32'hC, 0, "R11 bus clear then remote set");
    rmt(1, 32'h1, 1, 16'h08, 32'h1);
    rd(16'h00, 32'hC, 0, "R11 bus set then remote clear");
    rmt(1, 32'hC, 0, 0, 0);
    rd(16'h00, 32'h0, 0, "R11 remote clear");

    repeat (3) @(negedge clk);
    chk("R13 all reads returned", q_data.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule